// File: doc/BRIEF.md
# Receive Frame Page Writer

This block sits between a receive MAC and the shared packet memory of a small network controller. It takes one incoming frame at a time as a byte stream, with the frame length given alongside the first byte. It lays the frame out in a fixed-size memory page, one byte write per cycle. The stored image has four parts. A four-byte header holds a status word and a byte count. The payload comes next, padded with zeros for short frames. When CRC stripping is off, a four-byte CRC-32 follows. Two closing bytes end the image, and their value tells software whether the frame had an odd length.

The allocator supplies a free page number and an availability flag. The block takes the page when it accepts a frame. Once every byte of the image is in memory, it pushes the page number into the receive queue and raises a one-cycle receive-interrupt set pulse. The input stream cannot be stalled. The header is written last, after the padding, CRC and closing bytes. During those cycles the block is busy, and a frame that starts then is discarded whole.

Top module: `rxw_frame_writer`

## Requirements
- R1: A frame is taken only if all four of these hold on its first beat (in_valid and in_sof): rx_enable is 1, soft_reset is 0, page_avail is 1, and the byte count from R3 is at most 2048. Otherwise the frame causes no page_take, no memory write and no queue push.
- R2: Page bytes 0 (low) and 1 (high) hold a 16-bit status word. Bit 11 is set when the frame length is above 1518 bytes, and bit 12 is set when the length is odd. All other bits are 0.
- R3: Page bytes 2 (low) and 3 (high) hold the byte count. It equals B + 6, where B is 64 for frames shorter than 64 bytes and otherwise the frame length rounded down to even. The count grows by 4 more when strip_crc is 0.
- R4: Payload bytes are stored from byte 4 in arrival order. A frame shorter than 64 bytes is stored whole, its odd last byte included, and zeros then fill up to byte 67. A frame of 64 bytes or more stores only its first B bytes at this point.
- R5: When strip_crc is 0, bytes 4+B to 7+B hold the CRC, least-significant byte first. The CRC is CRC-32 with reflected polynomial 0xEDB88320, an initial value of all ones and a final inversion. It covers every received byte in arrival order, followed by the zero pad of a short frame.
- R6: The last two bytes of the image, at count-2 and count-1, are the frame's last data byte then 0x60 for an odd frame of 64 bytes or more. In every other case they are 0x00 then 0x40.
- R7: page_take pulses for one cycle on the accepted first beat. After the last image byte is written, q_push and rcv_set pulse together for one cycle with q_page equal to the taken page. No write follows in that frame.
- R8: A first beat that arrives while an earlier frame is still being written is dropped. All its bytes are ignored and no extra push occurs.
- R9: Each frame writes exactly count bytes, offsets 0 to count-1, each once.
- R10: All writes of a frame go to the page taken for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receive enable, sampled on a first beat |
| soft_reset | input | 1 | Soft reset active; frames are refused |
| strip_crc | input | 1 | 1: store no CRC |
| in_valid | input | 1 | Byte beat valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Frame byte |
| in_len | input | LEN_W | Frame length in bytes, valid with in_sof |
| page_avail | input | 1 | Allocator has a free page |
| page_num | input | PG_W | Free page number |
| page_take | output | 1 | Page consumed by an accepted frame |
| mem_we | output | 1 | Page memory write strobe |
| mem_page | output | PG_W | Write page number |
| mem_off | output | OFF_W | Byte offset within page |
| mem_data | output | 8 | Write byte |
| q_push | output | 1 | Push page into receive queue |
| q_page | output | PG_W | Page number pushed |
| rcv_set | output | 1 | Receive-interrupt set pulse |

## Verification
An error in the byte pointer or the phase sequencer shows up as a byte at the wrong offset, a gap, or a double write. These are visible in the page image as soon as the frame's push arrives. A stale or mis-seeded CRC register changes only the four CRC bytes, so every frame with stripping off exposes it. An odd-length latch error shows only in the closing bytes of long odd frames and in status bit 12. A busy-flag or acceptance error shows at once as a page_take, writes, or a push on a frame that had to be dropped. The sweep covers every short length in both CRC modes and the length limits around 1518 and the page size.

// File: rtl/rxw_pkg.sv
`timescale 1ns/1ps
package rxw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAD,
        ST_CRC,
        ST_TAIL0,
        ST_TAIL1,
        ST_HDR,
        ST_DONE
    } wr_state_e;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam int unsigned HDR_BYTES = 4;
endpackage

// File: rtl/rxw_crc_step.sv
`timescale 1ns/1ps
module rxw_crc_step
    import rxw_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);
    always_comb begin
        crc_out = crc_in ^ {24'h0, din};
        for (int b = 0; b < 8; b++) begin
            if (crc_out[0]) crc_out = (crc_out >> 1) ^ CRC_POLY;
            else            crc_out = crc_out >> 1;
        end
    end
endmodule

// File: rtl/rxw_layout.sv
`timescale 1ns/1ps
module rxw_layout #(
    parameter int unsigned LEN_W      = 12,
    parameter int unsigned PAGE_BYTES = 2048,
    parameter int unsigned MIN_FRAME  = 64,
    parameter int unsigned MAX_STD    = 1518,
    localparam int unsigned CNT_W     = LEN_W + 1
) (
    input  logic [LEN_W-1:0] len,
    input  logic             strip,
    output logic [CNT_W-1:0] count,
    output logic [15:0]      status,
    output logic             is_short,
    output logic             odd_long,
    output logic             fits
);
    logic [CNT_W-1:0] even_len;
    logic [CNT_W-1:0] body;
    logic             too_long;

    always_comb begin
        even_len = {1'b0, len[LEN_W-1:1], 1'b0};
        is_short = len < LEN_W'(MIN_FRAME);
        too_long = len > LEN_W'(MAX_STD);
        body     = is_short ? CNT_W'(MIN_FRAME) : even_len;
        count    = body + CNT_W'(6) + (strip ? CNT_W'(0) : CNT_W'(4));
        fits     = count <= CNT_W'(PAGE_BYTES);
        odd_long = len[0] && !is_short;
        status   = 16'h0000;
        status[12] = len[0];
        status[11] = too_long;
    end
endmodule

// File: rtl/rxw_frame_writer.sv
`timescale 1ns/1ps
module rxw_frame_writer
    import rxw_pkg::*;
#(
    parameter int unsigned NUM_PAGES  = 4,
    parameter int unsigned PAGE_BYTES = 2048,
    parameter int unsigned LEN_W      = 12,
    parameter int unsigned MIN_FRAME  = 64,
    parameter int unsigned MAX_STD    = 1518,
    localparam int unsigned PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_enable,
    input  logic             soft_reset,
    input  logic             strip_crc,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic [LEN_W-1:0] in_len,
    input  logic             page_avail,
    input  logic [PG_W-1:0]  page_num,
    output logic             page_take,
    output logic             mem_we,
    output logic [PG_W-1:0]  mem_page,
    output logic [OFF_W-1:0] mem_off,
    output logic [7:0]       mem_data,
    output logic             q_push,
    output logic [PG_W-1:0]  q_page,
    output logic             rcv_set
);
    localparam int unsigned PTR_W   = OFF_W + 1;
    localparam int unsigned CNT_W   = LEN_W + 1;
    localparam int unsigned PAD_END = HDR_BYTES + MIN_FRAME;

    typedef struct packed {
        wr_state_e        st;
        logic [PG_W-1:0]  page;
        logic [CNT_W-1:0] count;
        logic [15:0]      status;
        logic             odd_long;
        logic             is_short;
        logic             crc_on;
        logic [7:0]       held;
        logic [PTR_W-1:0] wptr;
        logic [1:0]       k;
        logic [31:0]      crc;
        logic             we;
        logic [OFF_W-1:0] waddr;
        logic [7:0]       wdata;
        logic             push;
        logic             rcv;
    } wr_regs_t;

    wr_regs_t q, d;

    logic [CNT_W-1:0] lay_count;
    logic [15:0]      lay_status;
    logic             lay_short;
    logic             lay_odd_long;
    logic             lay_fits;

    rxw_layout #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .MIN_FRAME  (MIN_FRAME),
        .MAX_STD    (MAX_STD)
    ) u_layout (
        .len      (in_len),
        .strip    (strip_crc),
        .count    (lay_count),
        .status   (lay_status),
        .is_short (lay_short),
        .odd_long (lay_odd_long),
        .fits     (lay_fits)
    );

    logic [31:0] crc_base;
    logic [7:0]  crc_din;
    logic [31:0] crc_nx;
    logic [31:0] crc_fin;

    always_comb begin
        crc_base = (q.st == ST_IDLE) ? 32'hFFFF_FFFF : q.crc;
        crc_din  = (q.st == ST_PAD)  ? 8'h00 : in_data;
        crc_fin  = ~q.crc;
    end

    rxw_crc_step u_crc (
        .crc_in  (crc_base),
        .din     (crc_din),
        .crc_out (crc_nx)
    );

    logic             accept;
    logic             take;
    logic             byte_now;
    logic             cur_ol;
    logic             cur_sh;
    logic             cur_co;
    logic [PTR_W-1:0] cur_ptr;
    logic [15:0]      count_ext;
    logic [7:0]       hdr_byte;
    logic [7:0]       crc_byte;

    always_comb begin
        accept    = rx_enable && !soft_reset && page_avail && lay_fits;
        count_ext = 16'(q.count);
        unique case (q.k)
            2'd0:    hdr_byte = q.status[7:0];
            2'd1:    hdr_byte = q.status[15:8];
            2'd2:    hdr_byte = count_ext[7:0];
            default: hdr_byte = count_ext[15:8];
        endcase
        crc_byte  = crc_fin[8*q.k +: 8];
    end

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        d.push   = 1'b0;
        d.rcv    = 1'b0;
        take     = 1'b0;
        byte_now = 1'b0;
        cur_ol   = q.odd_long;
        cur_sh   = q.is_short;
        cur_co   = q.crc_on;
        cur_ptr  = q.wptr;

        unique case (q.st)
            ST_IDLE: begin
                if (in_valid && in_sof && accept) begin
                    take       = 1'b1;
                    d.page     = page_num;
                    d.count    = lay_count;
                    d.status   = lay_status;
                    d.odd_long = lay_odd_long;
                    d.is_short = lay_short;
                    d.crc_on   = !strip_crc;
                    d.k        = 2'd0;
                    byte_now   = 1'b1;
                    cur_ol     = lay_odd_long;
                    cur_sh     = lay_short;
                    cur_co     = !strip_crc;
                    cur_ptr    = PTR_W'(HDR_BYTES);
                end
            end
            ST_DATA: begin
                if (in_valid) byte_now = 1'b1;
            end
            ST_PAD: begin
                d.we    = 1'b1;
                d.waddr = q.wptr[OFF_W-1:0];
                d.wdata = 8'h00;
                d.crc   = crc_nx;
                d.wptr  = q.wptr + PTR_W'(1);
                if (q.wptr == PTR_W'(PAD_END - 1))
                    d.st = q.crc_on ? ST_CRC : ST_TAIL0;
            end
            ST_CRC: begin
                d.we    = 1'b1;
                d.waddr = q.wptr[OFF_W-1:0];
                d.wdata = crc_byte;
                d.wptr  = q.wptr + PTR_W'(1);
                d.k     = q.k + 2'd1;
                if (q.k == 2'd3) d.st = ST_TAIL0;
            end
            ST_TAIL0: begin
                d.we    = 1'b1;
                d.waddr = q.wptr[OFF_W-1:0];
                d.wdata = q.odd_long ? q.held : 8'h00;
                d.wptr  = q.wptr + PTR_W'(1);
                d.st    = ST_TAIL1;
            end
            ST_TAIL1: begin
                d.we    = 1'b1;
                d.waddr = q.wptr[OFF_W-1:0];
                d.wdata = q.odd_long ? 8'h60 : 8'h40;
                d.k     = 2'd0;
                d.st    = ST_HDR;
            end
            ST_HDR: begin
                d.we    = 1'b1;
                d.waddr = OFF_W'(q.k);
                d.wdata = hdr_byte;
                d.k     = q.k + 2'd1;
                if (q.k == 2'd3) d.st = ST_DONE;
            end
            ST_DONE: begin
                d.push = 1'b1;
                d.rcv  = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (byte_now) begin
            d.crc = crc_nx;
            if (in_eof && cur_ol) begin
                d.held = in_data;
                d.wptr = cur_ptr;
            end else begin
                d.we    = 1'b1;
                d.waddr = cur_ptr[OFF_W-1:0];
                d.wdata = in_data;
                d.wptr  = cur_ptr + PTR_W'(1);
            end
            if (in_eof) begin
                if (cur_sh && (d.wptr < PTR_W'(PAD_END))) d.st = ST_PAD;
                else d.st = cur_co ? ST_CRC : ST_TAIL0;
            end else begin
                d.st = ST_DATA;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign page_take = take;
    assign mem_we    = q.we;
    assign mem_page  = q.page;
    assign mem_off   = q.waddr;
    assign mem_data  = q.wdata;
    assign q_push    = q.push;
    assign q_page    = q.page;
    assign rcv_set   = q.rcv;
endmodule

// File: rtl/rxw_frame_writer_chk.sv
`timescale 1ns/1ps
module rxw_frame_writer_chk #(
    parameter int unsigned PG_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_enable,
    input logic            soft_reset,
    input logic            page_avail,
    input logic [PG_W-1:0] page_num,
    input logic            page_take,
    input logic            mem_we,
    input logic [PG_W-1:0] mem_page,
    input logic            q_push,
    input logic [PG_W-1:0] q_page
);
    logic            busy;
    logic [PG_W-1:0] cur_page;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur_page <= '0;
        end else if (page_take) begin
            busy     <= 1'b1;
            cur_page <= page_num;
        end else if (q_push) begin
            busy     <= 1'b0;
        end
    end

    a_r1_take_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        page_take |-> (rx_enable && !soft_reset && page_avail));

    a_r8_no_take_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        page_take |-> !busy);

    a_r10_write_in_frame_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && mem_page == cur_page));

    a_r7_push_taken_page: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> (busy && q_page == cur_page && !mem_we));

    a_r7_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |=> !q_push);
endmodule

bind rxw_frame_writer rxw_frame_writer_chk #(.PG_W(PG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_enable  (rx_enable),
    .soft_reset (soft_reset),
    .page_avail (page_avail),
    .page_num   (page_num),
    .page_take  (page_take),
    .mem_we     (mem_we),
    .mem_page   (mem_page),
    .q_push     (q_push),
    .q_page     (q_page)
);

// File: tb/rxw_frame_writer_tb.sv
`timescale 1ns/1ps
module rxw_frame_writer_tb;
    localparam int CLK_P = 10;
    localparam int NP    = 4;
    localparam int PB    = 2048;
    localparam int LW    = 12;
    localparam int PGW   = 2;
    localparam int OFW   = 11;
    localparam int WD_LIMIT = 190000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rx_enable = 1'b1, soft_reset = 1'b0, strip_crc = 1'b0;
    logic           in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]     in_data = 8'h00;
    logic [LW-1:0]  in_len = '0;
    logic           page_avail = 1'b1;
    logic [PGW-1:0] page_num = '0;
    logic           page_take, mem_we, q_push, rcv_set;
    logic [PGW-1:0] mem_page, q_page;
    logic [OFW-1:0] mem_off;
    logic [7:0]     mem_data;

    rxw_frame_writer u_dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .soft_reset(soft_reset),
        .strip_crc(strip_crc), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .in_len(in_len), .page_avail(page_avail), .page_num(page_num),
        .page_take(page_take), .mem_we(mem_we), .mem_page(mem_page), .mem_off(mem_off),
        .mem_data(mem_data), .q_push(q_push), .q_page(q_page), .rcv_set(rcv_set)
    );

    always #(CLK_P/2) clk = ~clk;

    logic [7:0] sh_data [NP][PB];
    logic       sh_wr   [NP][PB];
    int n_vec = 0, n_bad = 0;
    int pushes = 0, rcvs = 0, takes = 0, dup_wr = 0, cyc = 0;
    int last_qpage = 0;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always begin
        @(negedge clk);
        #(CLK_P/4);
        cyc++;
        if (mem_we) begin
            if (sh_wr[mem_page][mem_off]) dup_wr++;
            sh_wr[mem_page][mem_off]   = 1'b1;
            sh_data[mem_page][mem_off] = mem_data;
        end
        if (q_push) begin pushes++; last_qpage = int'(q_page); end
        if (rcv_set) rcvs++;
        if (page_take) takes++;
        if (cyc > WD_LIMIT) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    task automatic clear_shadow();
        for (int p = 0; p < NP; p++)
            for (int o = 0; o < PB; o++) begin
                sh_wr[p][o] = 1'b0;
                sh_data[p][o] = 8'h00;
            end
        dup_wr = 0;
    endtask

    task automatic send(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_data  = fb(i, seed);
            in_len   = LW'(len);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic verify(input int pg, input int len, input bit strip, input int seed);
        int body, cnt, tot, on_pg, tail, exp_b, act;
        bit odd_long;
        logic [31:0] c;
        logic [15:0] st;
        body = (len < 64) ? 64 : (len & ~1);
        cnt  = body + 6 + (strip ? 0 : 4);
        odd_long = (len >= 64) && (len % 2 == 1);
        st = 16'h0;
        if (len > 1518) st = st | 16'h0800;
        if (len % 2 == 1) st = st | 16'h1000;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < ((len < 64) ? 64 : len); i++) begin
            c = c ^ {24'h0, ((i < len) ? fb(i, seed) : 8'h00)};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        tot = 0; on_pg = 0;
        for (int p = 0; p < NP; p++)
            for (int o = 0; o < PB; o++)
                if (sh_wr[p][o]) begin tot++; if (p == pg) on_pg++; end
        chk("R9 total writes", tot, cnt);
        chk("R9 duplicate writes", dup_wr, 0);
        chk("R10 writes on taken page", on_pg, cnt);
        tail = 4 + body + (strip ? 0 : 4);
        for (int o = 0; o < cnt; o++) begin
            act = sh_wr[pg][o] ? int'(sh_data[pg][o]) : 'h1ff;
            if (o < 2) begin
                exp_b = (o == 0) ? int'(st[7:0]) : int'(st[15:8]);
                chk("R2 status", act, exp_b);
            end else if (o < 4) begin
                exp_b = (o == 2) ? (cnt & 255) : (cnt >> 8);
                chk("R3 count", act, exp_b);
            end else if (o < 4 + body) begin
                exp_b = (o - 4 < len) ? int'(fb(o - 4, seed)) : 0;
                chk("R4 payload", act, exp_b);
            end else if (o < tail) begin
                exp_b = int'(c[8*(o-4-body) +: 8]);
                chk("R5 crc", act, exp_b);
            end else if (o == tail) begin
                exp_b = odd_long ? int'(fb(len - 1, seed)) : 0;
                chk("R6 tail byte", act, exp_b);
            end else begin
                exp_b = odd_long ? 'h60 : 'h40;
                chk("R6 control byte", act, exp_b);
            end
        end
    endtask

    task automatic run_frame(input int len, input bit strip, input int seed,
                             input int pg, input bit exp_ok);
        int p0, r0, t0, t, tot;
        clear_shadow();
        p0 = pushes; r0 = rcvs; t0 = takes;
        strip_crc = strip;
        page_num  = PGW'(pg);
        send(len, seed);
        if (exp_ok) begin
            t = 0;
            while (pushes == p0 && t < 400) begin @(negedge clk); t++; end
            repeat (4) @(negedge clk);
            chk("R7 one page_take", takes - t0, 1);
            chk("R7 one push", pushes - p0, 1);
            chk("R7 one rcv_set", rcvs - r0, 1);
            chk("R7 pushed page", last_qpage, pg);
            verify(pg, len, strip, seed);
        end else begin
            repeat (100) @(negedge clk);
            tot = 0;
            for (int p = 0; p < NP; p++)
                for (int o = 0; o < PB; o++)
                    if (sh_wr[p][o]) tot++;
            chk("R1 dropped: no take", takes - t0, 0);
            chk("R1 dropped: no push", pushes - p0, 0);
            chk("R1 dropped: no writes", tot, 0);
        end
    endtask

    initial begin
        int fr;
        int p0, t0, t;
        clear_shadow();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #(CLK_P/4);
        chk("R7 reset mem_we", int'(mem_we), 0);
        chk("R7 reset q_push", int'(q_push), 0);
        chk("R7 reset rcv_set", int'(rcv_set), 0);
        chk("R7 reset page_take", int'(page_take), 0);

        fr = 0;
        for (int len = 1; len <= 72; len++)
            for (int s = 0; s < 2; s++) begin
                run_frame(len, s[0], fr, fr % NP, 1'b1);
                fr++;
            end
        for (int len = 1517; len <= 1520; len++)
            for (int s = 0; s < 2; s++) begin
                run_frame(len, s[0], fr, fr % NP, 1'b1);
                fr++;
            end
        // R3 page size limit: 2039 with CRC fits exactly, 2040 does not
        run_frame(2039, 1'b0, 7, 1, 1'b1);
        run_frame(2040, 1'b0, 8, 2, 1'b0);
        run_frame(2043, 1'b1, 9, 3, 1'b1);
        run_frame(2044, 1'b1, 10, 0, 1'b0);

        // R1 refusal conditions
        rx_enable = 1'b0;  run_frame(10, 1'b0, 3, 1, 1'b0); rx_enable = 1'b1;
        soft_reset = 1'b1; run_frame(10, 1'b0, 4, 2, 1'b0); soft_reset = 1'b0;
        page_avail = 1'b0; run_frame(10, 1'b1, 5, 3, 1'b0); page_avail = 1'b1;
        run_frame(11, 1'b1, 6, 3, 1'b1);

        // R8 frame arriving while busy is dropped whole
        clear_shadow();
        p0 = pushes; t0 = takes;
        strip_crc = 1'b0; page_num = 2'd1;
        send(71, 12);
        page_num = 2'd2;
        send(20, 13);
        t = 0;
        while (pushes == p0 && t < 400) begin @(negedge clk); t++; end
        repeat (120) @(negedge clk);
        chk("R8 one take only", takes - t0, 1);
        chk("R8 one push only", pushes - p0, 1);
        chk("R8 pushed first page", last_qpage, 1);
        verify(1, 71, 1'b0, 12);

        summary();
    end
endmodule